// File: doc/BRIEF.md
# Pulse-Width Autobaud Single-Wire Responder

This block sits on one open-drain wire that has an external pullup. A host starts an exchange by pulling the wire low for a while and then letting it go. The block counts how many system-clock cycles the wire stayed low. If that count falls inside a configured window, the count becomes the bit period of the reply. The block then asks a measurement engine for a 16-bit result and waits for it.

Once the result arrives, the block waits one further bit period so the host can turn its pin around. It then sends the result back on the same wire as two UART characters, high byte first. A programmable idle gap separates the two characters. The block never drives the wire high. A logic 1 is produced by releasing the wire, and a logic 0 by enabling the pull-down.

While it is transmitting, the block watches the wire during every interval in which it has released it. If it sees the wire low in such an interval, another driver is present, and the block raises a collision flag. The flag stays set until the next accepted trigger.

Top module: `autobaud_wire_resp`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `line_oe_o`, `acq_req_o` and `collision_o` are all 0.
- R2: A low pulse lasting W cycles, with MIN_W ≤ W ≤ MAX_W, produces exactly one `acq_req_o` pulse of one cycle, within a few cycles after the wire returns high.
- R3: A pulse shorter than MIN_W or longer than MAX_W produces no request and no drive. The width counter saturates instead of wrapping, so a pulse longer than 2^CW − 1 cycles is rejected.
- R4: The first start bit begins between W and W+2 cycles after the cycle in which `acq_done_i` is seen high. `line_oe_o` is 0 while `acq_req_o` is high.
- R5: Each character is framed as follows, and each bit lasts exactly W cycles:
  - a start bit, with `line_oe_o` at 1;
  - 8 data bits, LSB first, with `line_oe_o` equal to the inverted data bit;
  - a stop bit, with `line_oe_o` at 0.
  The first character carries `acq_data_i[15:8]` and the second carries `acq_data_i[7:0]`.
- R6: The second start bit begins exactly 10·W + (10 + 4·G)·GAP_UNIT cycles after the first one. G is the `gap_code_i` value captured when the trigger is accepted.
- R7: The block drives only low. The wire level is high whenever neither `line_oe_o` nor another driver pulls it down.
- R8: A low level seen on the wire while the block has the wire released, anywhere from the first start bit to the end of the second stop bit, sets `collision_o`. The flag stays set until the next accepted trigger clears it. A reply without interference leaves it at 0.
- R9: The block's own low bits are never taken as triggers. One complete exchange yields exactly one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Sampled level of the shared wire (asynchronous) |
| line_oe_o | output | 1 | 1 = pull the wire low; 0 = release it |
| gap_code_i | input | 8 | Inter-character gap code G, captured when a trigger is accepted |
| acq_req_o | output | 1 | One-cycle request to the measurement engine |
| acq_done_i | input | 1 | Measurement engine result valid |
| acq_data_i | input | 16 | Measurement result |
| collision_o | output | 1 | Foreign low level seen while the wire was released |

## Verification
The hardest condition to reach is a foreign low level during an interval in which the block itself has released the wire. That interval exists only in the middle of a reply, and its position depends on the measured width and the gap code. The bench records the cycle of the first start bit. From it, the bench computes the midpoint of the inter-character gap and pulls the wire there for three cycles. It then confirms that the flag is set and that the next accepted trigger clears it. The saturation corner is reached with a 300-cycle pulse against an 8-bit width counter. A wrapping counter would read this pulse as an acceptable width of 44.

// File: rtl/awr_pkg.sv
package awr_pkg;
  localparam int BYTE_W  = 8;
  localparam int FRAME_W = BYTE_W + 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_TURN,
    ST_TX_HI,
    ST_GAP,
    ST_TX_LO
  } seq_state_t;
endpackage

// File: rtl/awr_pulse_meter.sv
module awr_pulse_meter #(
  parameter int CW    = 12,
  parameter int MIN_W = 4,
  parameter int MAX_W = 2000,
  parameter int SYNC  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          line_i,
  output logic          line_s_o,
  output logic          accept_o,
  output logic [CW-1:0] width_o
);
  localparam logic [CW-1:0] CNT_TOP = '1;
  localparam logic [CW-1:0] LO_LIM  = CW'(MIN_W);
  localparam logic [CW-1:0] HI_LIM  = CW'(MAX_W);

  logic [SYNC-1:0] sync_q;
  logic            meas_q;
  logic [CW-1:0]   cnt_q;

  // Synchroniser: the wire idles high, so the chain resets to all ones.
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC-2:0], line_i};
  end
  assign line_s_o = sync_q[SYNC-1];

  // Low-time counter; it stops at its top value rather than wrapping.
  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      meas_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!meas_q) begin
      if (!line_s_o) begin
        meas_q <= 1'b1;
        cnt_q  <= CW'(1);
      end
    end else if (line_s_o) begin
      meas_q <= 1'b0;
    end else if (cnt_q != CNT_TOP) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign accept_o = en_i && meas_q && line_s_o && (cnt_q >= LO_LIM) && (cnt_q <= HI_LIM);
  assign width_o  = cnt_q;
endmodule

// File: rtl/awr_uart_tx.sv
module awr_uart_tx
  import awr_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic [CW-1:0]     bit_per_i,
  output logic              drive_low_o,
  output logic              busy_o,
  output logic              done_o
);
  logic [FRAME_W-1:0] frame_q;
  logic [3:0]         idx_q;
  logic [CW-1:0]      tick_q;
  logic               busy_q;
  logic               drive_q;
  logic               bit_end;

  assign bit_end = (tick_q == bit_per_i - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '1;
      idx_q   <= '0;
      tick_q  <= '0;
      busy_q  <= 1'b0;
      drive_q <= 1'b0;
    end else if (start_i) begin
      frame_q <= {1'b1, data_i, 1'b0};
      idx_q   <= '0;
      tick_q  <= '0;
      busy_q  <= 1'b1;
      drive_q <= 1'b1;
    end else if (busy_q) begin
      if (bit_end) begin
        tick_q <= '0;
        if (idx_q == 4'(FRAME_W - 1)) begin
          busy_q  <= 1'b0;
          drive_q <= 1'b0;
        end else begin
          idx_q   <= idx_q + 4'd1;
          frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
          drive_q <= ~frame_q[1];
        end
      end else begin
        tick_q <= tick_q + CW'(1);
      end
    end
  end

  assign drive_low_o = drive_q;
  assign busy_o      = busy_q;
  assign done_o      = busy_q && bit_end && (idx_q == 4'(FRAME_W - 1));
endmodule

// File: rtl/autobaud_wire_resp.sv
module autobaud_wire_resp
  import awr_pkg::*;
#(
  parameter int CW       = 12,
  parameter int MIN_W    = 4,
  parameter int MAX_W    = 2000,
  parameter int GAP_UNIT = 8,
  parameter int SYNC     = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        line_i,
  output logic        line_oe_o,
  input  logic [7:0]  gap_code_i,
  output logic        acq_req_o,
  input  logic        acq_done_i,
  input  logic [15:0] acq_data_i,
  output logic        collision_o
);
  localparam int GAP_MAX = (10 + 4 * 255) * GAP_UNIT;
  localparam int GW      = $clog2(GAP_MAX + 1);
  localparam int TW      = (GW > CW) ? GW : CW;

  seq_state_t        state_q;
  logic [CW-1:0]     bit_per_q;
  logic [TW-1:0]     gap_q;
  logic [TW-1:0]     timer_q;
  logic [15:0]       data_q;
  logic              req_q;
  logic              err_q;
  logic [SYNC:0]     oe_hist_q;

  logic              line_s;
  logic              accept;
  logic [CW-1:0]     width;
  logic              tx_start;
  logic [BYTE_W-1:0] tx_byte;
  logic              tx_drive;
  logic              tx_busy;
  logic              tx_done;
  logic [TW-1:0]     gap_len_c;
  logic              released;
  logic              in_reply;

  awr_pulse_meter #(
    .CW(CW), .MIN_W(MIN_W), .MAX_W(MAX_W), .SYNC(SYNC)
  ) u_meter (
    .clk      (clk),
    .rst      (rst),
    .en_i     (state_q == ST_IDLE),
    .line_i   (line_i),
    .line_s_o (line_s),
    .accept_o (accept),
    .width_o  (width)
  );

  assign tx_start = ((state_q == ST_TURN) || (state_q == ST_GAP)) && (timer_q == '0);
  assign tx_byte  = (state_q == ST_TURN) ? data_q[15:8] : data_q[7:0];

  awr_uart_tx #(.CW(CW)) u_tx (
    .clk         (clk),
    .rst         (rst),
    .start_i     (tx_start),
    .data_i      (tx_byte),
    .bit_per_i   (bit_per_q),
    .drive_low_o (tx_drive),
    .busy_o      (tx_busy),
    .done_o      (tx_done)
  );

  assign gap_len_c = TW'((32'd10 + 32'd4 * {24'd0, gap_code_i}) * GAP_UNIT);

  // A level seen through the synchroniser belongs to our own pull-down for
  // SYNC+1 cycles after release, so the history masks that window.
  assign released = !tx_drive && !(|oe_hist_q);
  assign in_reply = (state_q == ST_TX_HI) || (state_q == ST_GAP) || (state_q == ST_TX_LO);

  always_ff @(posedge clk) begin
    if (rst) oe_hist_q <= '0;
    else     oe_hist_q <= {oe_hist_q[SYNC-1:0], tx_drive};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      bit_per_q <= CW'(MIN_W);
      gap_q     <= '0;
      timer_q   <= '0;
      data_q    <= '0;
      req_q     <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (in_reply && released && !line_s) err_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          bit_per_q <= width;
          gap_q     <= gap_len_c;
          req_q     <= 1'b1;
          err_q     <= 1'b0;
          state_q   <= ST_WAIT;
        end
        ST_WAIT: if (acq_done_i) begin
          data_q  <= acq_data_i;
          timer_q <= TW'(bit_per_q) - TW'(1);
          state_q <= ST_TURN;
        end
        ST_TURN: begin
          if (timer_q == '0) state_q <= ST_TX_HI;
          else               timer_q <= timer_q - TW'(1);
        end
        ST_TX_HI: if (tx_done) begin
          timer_q <= gap_q - TW'(1);
          state_q <= ST_GAP;
        end
        ST_GAP: begin
          if (timer_q == '0) state_q <= ST_TX_LO;
          else               timer_q <= timer_q - TW'(1);
        end
        ST_TX_LO: if (tx_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign line_oe_o   = tx_drive;
  assign acq_req_o   = req_q;
  assign collision_o = err_q;
endmodule

// File: rtl/awr_checker.sv
module awr_checker (
  input logic clk,
  input logic rst,
  input logic line_oe_o,
  input logic acq_req_o,
  input logic collision_o
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!line_oe_o && !acq_req_o && !collision_o));

  a_r2_req_one_cycle: assert property (@(posedge clk) disable iff (rst)
    acq_req_o |=> !acq_req_o);

  a_r4_no_drive_with_req: assert property (@(posedge clk) disable iff (rst)
    acq_req_o |-> !line_oe_o);

  a_r4_drive_not_after_req: assert property (@(posedge clk) disable iff (rst)
    $rose(line_oe_o) |-> !$past(acq_req_o));

  a_r8_clear_on_trigger: assert property (@(posedge clk) disable iff (rst)
    $fell(collision_o) |-> acq_req_o);
endmodule

bind autobaud_wire_resp awr_checker u_awr_chk (
  .clk         (clk),
  .rst         (rst),
  .line_oe_o   (line_oe_o),
  .acq_req_o   (acq_req_o),
  .collision_o (collision_o)
);

// File: tb/autobaud_wire_resp_tb_top.sv
module autobaud_wire_resp_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW         = 8;
  localparam int MIN_W      = 4;
  localparam int MAX_W      = 200;
  localparam int GAP_UNIT   = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_low = 1'b0;
  logic        acq_done = 1'b0;
  logic [15:0] acq_data = '0;
  logic [7:0]  gap_code = '0;
  logic        line_oe;
  logic        acq_req;
  logic        collision;
  logic        line;

  int cyc = 0;
  int req_count = 0;
  int checks = 0;
  int errors = 0;

  // R7: open-drain wire with pullup, pulled by either side
  assign line = !(host_low || line_oe);

  autobaud_wire_resp #(
    .CW(CW), .MIN_W(MIN_W), .MAX_W(MAX_W), .GAP_UNIT(GAP_UNIT), .SYNC(2)
  ) dut_i (
    .clk         (clk),
    .rst         (rst),
    .line_i      (line),
    .line_oe_o   (line_oe),
    .gap_code_i  (gap_code),
    .acq_req_o   (acq_req),
    .acq_done_i  (acq_done),
    .acq_data_i  (acq_data),
    .collision_o (collision)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst && acq_req) req_count <= req_count + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic host_pulse(input int w);
    @(negedge clk);
    host_low = 1'b1;
    repeat (w) @(negedge clk);
    host_low = 1'b0;
  endtask

  task automatic check_byte(input int t0, input int w, input logic [7:0] b, input string tag);
    for (int k = 0; k < 10; k++) begin
      logic bitv;
      wait_until(t0 + k * w + w / 2);
      bitv = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : b[k-1];
      chk(line_oe == !bitv, tag, int'(line_oe), int'(!bitv));
    end
  endtask

  task automatic run_case(input int w, input int code, input logic [15:0] d,
                          input bit accept, input bit inject);
    int r0, td, t1, t2, g, guard;
    bit drove;
    r0 = req_count;
    g = (10 + 4 * code) * GAP_UNIT;
    gap_code = 8'(code);
    host_pulse(w);
    repeat (6) @(negedge clk);
    if (!accept) begin
      chk(req_count == r0, "R3 out-of-window pulse requested", req_count - r0, 0);
      drove = 1'b0;
      repeat (20) begin
        @(negedge clk);
        if (line_oe) drove = 1'b1;
      end
      chk(!drove, "R3 out-of-window pulse drove wire", int'(drove), 0);
      return;
    end
    chk(req_count == r0 + 1, "R2 request count", req_count - r0, 1);
    chk(!collision, "R8 flag cleared by trigger", int'(collision), 0);
    repeat (2) @(negedge clk);
    acq_done = 1'b1;
    acq_data = d;
    td = cyc;
    @(negedge clk);
    acq_done = 1'b0;
    guard = 0;
    while (!line_oe && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    t1 = cyc;
    chk((t1 - td >= w) && (t1 - td <= w + 2), "R4 turnaround", t1 - td, w);
    check_byte(t1, w, d[15:8], "R5 high byte bit");
    if (inject) begin
      wait_until(t1 + 10 * w + g / 2);
      host_low = 1'b1;
      repeat (3) @(negedge clk);
      host_low = 1'b0;
    end
    wait_until(t1 + 10 * w - 1);
    guard = 0;
    while (!line_oe && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    t2 = cyc;
    chk(t2 - t1 == 10 * w + g, "R6 start-to-start spacing", t2 - t1, 10 * w + g);
    check_byte(t2, w, d[7:0], "R5 low byte bit");
    wait_until(t2 + 10 * w + 4);
    chk(!line_oe, "R5 wire released after reply", int'(line_oe), 0);
    chk(collision == inject, "R8 collision flag", int'(collision), int'(inject));
    chk(req_count == r0 + 1, "R9 own bits not triggers", req_count - r0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!line_oe && !acq_req && !collision, "R1 outputs in reset",
        int'({line_oe, acq_req, collision}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!line_oe && !acq_req && !collision, "R1 outputs after reset",
        int'({line_oe, acq_req, collision}), 0);

    for (int w = MIN_W; w <= 12; w++)
      run_case(w, (w * 37) % 256, {8'(w * 17), 8'(~(w * 5))}, 1'b1, 1'b0);
    run_case(16, 0, 16'h8001, 1'b1, 1'b0);
    run_case(MAX_W, 255, 16'hA55A, 1'b1, 1'b0);
    run_case(2, 3, 16'h0000, 1'b0, 1'b0);
    run_case(MIN_W - 1, 3, 16'h0000, 1'b0, 1'b0);
    run_case(MAX_W + 1, 3, 16'h0000, 1'b0, 1'b0);
    run_case(300, 3, 16'h0000, 1'b0, 1'b0);
    run_case(6, 5, 16'h3CC3, 1'b1, 1'b1);
    run_case(9, 3, 16'hFF00, 1'b1, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule